// File: doc/BRIEF.md
# Binary-Field Inverter over GF(2^193)

This block returns the multiplicative inverse of a nonzero element of GF(2^193) in polynomial basis, with the field defined by the trinomial x^193 + x^15 + 1. A host places an element on `operand`, raises `start` for one cycle and, a fixed number of cycles later, sees `done` pulse with the inverse on `result`.

Internally the exponent 2^193 − 2 is split into two half-length pieces. A forward chain raises the operand to 2^k − 1 with repeated squarings. A backward chain raises it to 1 − 2^-k with repeated square roots. Both chains follow the addition chain 1, 2, 3, 6, 12, 24, 48, 96 and take turns on one shared field multiplier. The answer is the square of the forward value at 96 multiplied by the backward value at 96. A step counter addresses a table of 17-bit control words. Each word chooses the register-file entries to read and write, the multiplier's first operand, and how many squarings or roots each chain register receives. Each word is registered one edge before the step it governs.

Top module: `gf193_inverter`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is 0 and `result` is all zeros.
- R2: For every nonzero operand, the field product of `operand` and `result` is 1 (bit 0 set, all other bits clear) in the cycle where `done` is high, with reduction by x^193 + x^15 + 1 (bit i stands for x^i).
- R3: The inverse of the element 1 (only bit 0 set) is 1.
- R4: The inverse of x (only bit 1 set) is x^192 + x^14 (bits 192 and 14 set, all others clear), and the inverse of that element is x.
- R5: `done` is high for exactly one cycle, and it rises after the 21st rising edge that follows the edge which accepted `start`.
- R6: A `start` that arrives while an inversion is in progress is ignored. The running inversion completes on time with its own correct result, and no extra `done` follows.
- R7: While the block is idle and `start` is low, `result` keeps the last inverse unchanged.
- R8: A `start` asserted in the same cycle as `done` is accepted, and a new inversion begins at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an inversion of `operand`; taken only when idle |
| operand | input | 193 | Nonzero field element to invert, bit i = coefficient of x^i |
| done | output | 1 | One-cycle pulse marking `result` valid |
| result | output | 193 | Inverse of the accepted operand, held until the next request |

## Verification
Any fault in a control word, a power count or a register-file address changes the exponent the block applies. The result is then a different field element, and multiplying it by the operand no longer gives 1 in the cycle where `done` is high. The fault therefore shows 21 cycles after the request, not at some later point. A fault in the step counter moves the `done` pulse off its fixed latency, or lets a start that arrives mid-operation restart the work. This shows up as a latency or a result mismatch on that same request.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

    localparam int FIELD_M    = 193;
    localparam int FIELD_K    = 15;
    localparam int PROD_W     = 2 * FIELD_M - 1;
    localparam int ADDR_W     = 4;
    localparam int RF_DEPTH   = 2 ** ADDR_W;
    localparam int POW_W      = 3;
    localparam int POW_STAGES = 12;
    localparam int N_STEPS    = 21;
    localparam int STEP_W     = $clog2(N_STEPS + 1);
    localparam int ROOT_SH_M  = (FIELD_M + 1) / 2;
    localparam int ROOT_SH_K  = (FIELD_K + 1) / 2;

    // Address value meaning "no write" on the write port, "constant one" on the read port
    localparam logic [ADDR_W-1:0] ADDR_NONE = '1;

    typedef logic [FIELD_M-1:0] elem_t;

    localparam elem_t FIELD_ONE = elem_t'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] wr_addr;
        logic [ADDR_W-1:0] rd_addr;
        logic              mul_sel_root;  // 1: multiplier takes the root-chain register
        logic              sq_recirc;     // 1: squarer fed from its own register
        logic              rt_recirc;     // 1: rooter fed from its own register
        logic [POW_W-1:0]  sq_code;       // 0 keeps the register
        logic [POW_W-1:0]  rt_code;
    } ctrl_word_t;

    localparam ctrl_word_t CTRL_NOP = '{wr_addr: ADDR_NONE, rd_addr: ADDR_NONE,
                                        mul_sel_root: 1'b0, sq_recirc: 1'b0,
                                        rt_recirc: 1'b0, sq_code: '0, rt_code: '0};

    function automatic int pow_count(input logic [POW_W-1:0] code);
        case (code)
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd4:    return 6;
            3'd5:    return 12;
            default: return 0;
        endcase
    endfunction

    function automatic elem_t gf_reduce(input logic [PROD_W-1:0] w);
        logic [PROD_W-1:0] t;
        t = w;
        for (int i = PROD_W - 1; i >= FIELD_M; i--) begin
            if (t[i]) begin
                t[i - FIELD_M]           = ~t[i - FIELD_M];
                t[i - FIELD_M + FIELD_K] = ~t[i - FIELD_M + FIELD_K];
            end
        end
        return t[FIELD_M-1:0];
    endfunction

    function automatic elem_t gf_mul(input elem_t a, input elem_t b);
        logic [PROD_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < FIELD_M; i++) begin
            if (b[i]) acc = acc ^ ({{(FIELD_M - 1){1'b0}}, a} << i);
        end
        return gf_reduce(acc);
    endfunction

    function automatic elem_t gf_sqr(input elem_t a);
        logic [PROD_W-1:0] w;
        w = '0;
        for (int i = 0; i < FIELD_M; i++) w[2*i] = a[i];
        return gf_reduce(w);
    endfunction

    // sqrt(x) = x^ROOT_SH_M + x^ROOT_SH_K for odd M and K; no reduction needed
    function automatic elem_t gf_sqrt(input elem_t a);
        elem_t ev;
        elem_t od;
        ev = '0;
        od = '0;
        for (int i = 0; 2 * i < FIELD_M; i++)     ev[i] = a[2*i];
        for (int i = 0; 2 * i + 1 < FIELD_M; i++) od[i] = a[2*i+1];
        return ev ^ (od << ROOT_SH_M) ^ (od << ROOT_SH_K);
    endfunction

    function automatic ctrl_word_t mk_word(input logic [ADDR_W-1:0] wr, input logic [ADDR_W-1:0] rd,
                                           input logic msel, input logic sr, input logic rr,
                                           input logic [POW_W-1:0] sq, input logic [POW_W-1:0] rt);
        ctrl_word_t c;
        c.wr_addr      = wr;
        c.rd_addr      = rd;
        c.mul_sel_root = msel;
        c.sq_recirc    = sr;
        c.rt_recirc    = rr;
        c.sq_code      = sq;
        c.rt_code      = rt;
        return c;
    endfunction

    // Entries: 0 operand, 1 first root value, 2 latest forward value, 3 latest backward value
    function automatic ctrl_word_t ctrl_rom(input logic [STEP_W-1:0] step);
        case (step)
            5'd1:  return mk_word(4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1);
            5'd2:  return mk_word(4'h1, 4'hF, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0);
            5'd3:  return mk_word(4'h2, 4'h0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1);
            5'd4:  return mk_word(4'h3, 4'h1, 1'b1, 1'b0, 1'b0, 3'd1, 3'd0);
            5'd5:  return mk_word(4'h2, 4'h0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1);
            5'd6:  return mk_word(4'h3, 4'h1, 1'b1, 1'b0, 1'b0, 3'd3, 3'd0);
            5'd7:  return mk_word(4'h2, 4'h2, 1'b0, 1'b0, 1'b0, 3'd0, 3'd3);
            5'd8:  return mk_word(4'h3, 4'h3, 1'b1, 1'b0, 1'b0, 3'd4, 3'd0);
            5'd9:  return mk_word(4'h2, 4'h2, 1'b0, 1'b0, 1'b0, 3'd0, 3'd4);
            5'd10: return mk_word(4'h3, 4'h3, 1'b1, 1'b0, 1'b0, 3'd5, 3'd0);
            5'd11: return mk_word(4'h2, 4'h2, 1'b0, 1'b0, 1'b0, 3'd0, 3'd5);
            5'd12: return mk_word(4'h3, 4'h3, 1'b1, 1'b0, 1'b0, 3'd5, 3'd0);
            5'd13: return mk_word(4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 3'd5, 3'd5);
            5'd14: return mk_word(4'h2, 4'h2, 1'b0, 1'b0, 1'b1, 3'd0, 3'd5);
            5'd15: return mk_word(4'h3, 4'h3, 1'b1, 1'b0, 1'b0, 3'd5, 3'd0);
            5'd16: return mk_word(4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 3'd5, 3'd5);
            5'd17: return mk_word(4'hF, 4'hF, 1'b0, 1'b1, 1'b1, 3'd5, 3'd5);
            5'd18: return mk_word(4'hF, 4'hF, 1'b0, 1'b1, 1'b1, 3'd5, 3'd5);
            5'd19: return mk_word(4'h2, 4'h2, 1'b0, 1'b0, 1'b1, 3'd0, 3'd5);
            5'd20: return mk_word(4'h3, 4'h3, 1'b1, 1'b0, 1'b0, 3'd1, 3'd0);
            5'd21: return mk_word(4'h4, 4'h3, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
            default: return CTRL_NOP;
        endcase
    endfunction

endpackage

// File: rtl/gfinv_mul.sv
module gfinv_mul
    import gfinv_pkg::*;
(
    input  elem_t a,
    input  elem_t b,
    output elem_t p
);
    assign p = gf_mul(a, b);
endmodule

// File: rtl/gfinv_pow.sv
module gfinv_pow
    import gfinv_pkg::*;
#(
    parameter bit ROOT   = 1'b0,
    parameter int STAGES = POW_STAGES
) (
    input  elem_t            x,
    input  logic [POW_W-1:0] code,
    output elem_t            y
);
    localparam int IDX_W = $clog2(STAGES + 1);

    elem_t            chain [STAGES+1];
    logic [IDX_W-1:0] idx;

    assign chain[0] = x;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (ROOT) begin : g_root
            assign chain[s+1] = gf_sqrt(chain[s]);
        end else begin : g_square
            assign chain[s+1] = gf_sqr(chain[s]);
        end
    end

    always_comb begin
        idx = '0;
        if (pow_count(code) <= STAGES) idx = IDX_W'(pow_count(code));
        y = chain[idx];
    end
endmodule

// File: rtl/gfinv_seq.sv
module gfinv_seq
    import gfinv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       load,
    output ctrl_word_t cw,
    output logic       done
);
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_nxt;
    ctrl_word_t        ctrl_q;
    logic              done_q;

    assign step_nxt = step_q + 1'b1;
    assign load     = start && (step_q == '0);
    assign cw       = ctrl_q;
    assign done     = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            ctrl_q <= CTRL_NOP;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (step_q == '0) begin
                if (start) begin
                    step_q <= step_nxt;
                    ctrl_q <= ctrl_rom(step_nxt);
                end
            end else if (step_q == STEP_W'(N_STEPS)) begin
                step_q <= '0;
                ctrl_q <= CTRL_NOP;
                done_q <= 1'b1;
            end else begin
                step_q <= step_nxt;
                ctrl_q <= ctrl_rom(step_nxt);
            end
        end
    end
endmodule

// File: rtl/gf193_inverter.sv
module gf193_inverter
    import gfinv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FIELD_M-1:0] operand,
    output logic               done,
    output logic [FIELD_M-1:0] result
);
    ctrl_word_t        cw;
    logic              load;
    elem_t             t1_q, t2_q, pr_q;
    elem_t             rf_q [RF_DEPTH];
    elem_t             mul_a, mul_b, prod, wr_data;
    elem_t             sq_in, rt_in, sq_out, rt_out;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_en;

    gfinv_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .cw    (cw),
        .done  (done)
    );

    assign mul_a = cw.mul_sel_root ? t2_q : t1_q;
    assign mul_b = (cw.rd_addr == ADDR_NONE) ? FIELD_ONE : rf_q[cw.rd_addr];

    gfinv_mul u_mul (
        .a (mul_a),
        .b (mul_b),
        .p (prod)
    );

    assign sq_in = cw.sq_recirc ? t1_q : pr_q;
    assign rt_in = cw.rt_recirc ? t2_q : pr_q;

    gfinv_pow #(.ROOT(1'b0), .STAGES(POW_STAGES)) u_sqr (
        .x    (sq_in),
        .code (cw.sq_code),
        .y    (sq_out)
    );

    gfinv_pow #(.ROOT(1'b1), .STAGES(POW_STAGES)) u_root (
        .x    (rt_in),
        .code (cw.rt_code),
        .y    (rt_out)
    );

    // Input mux: operand on the accepting cycle, multiplier output afterwards
    assign wr_data = load ? operand : prod;
    assign wr_addr = load ? '0 : cw.wr_addr;
    assign wr_en   = load || (cw.wr_addr != ADDR_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_q <= '0;
            t2_q <= '0;
            pr_q <= '0;
        end else begin
            if (wr_en)             pr_q <= wr_data;
            if (cw.sq_code != '0)  t1_q <= sq_out;
            if (cw.rt_code != '0)  t2_q <= rt_out;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) rf_q[wr_addr] <= wr_data;
    end

    assign result = pr_q;
endmodule

// File: rtl/gfinv_checker.sv
module gfinv_checker
    import gfinv_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  start,
    input logic  done,
    input elem_t result
);
    localparam logic [STEP_W-1:0] LAT = STEP_W'(N_STEPS);

    logic [STEP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (cnt == '0 && start)  cnt <= STEP_W'(1);
        else if (cnt == LAT)          cnt <= '0;
        else if (cnt != '0)           cnt <= cnt + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!done && result == '0));

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAT) |=> done);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    no_early_done_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && cnt != LAT) |=> !done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !start) |=> $stable(result));
endmodule

bind gf193_inverter gfinv_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .result (result)
);

// File: tb/test_gf193_inverter.sv
module test_gf193_inverter;
    localparam int M = 193;
    localparam int K = 15;
    localparam int EXP_LAT = 21;
    localparam logic [M-1:0] ONE = M'(1);
    localparam logic [M-1:0] RED = (M'(1) << K) | M'(1);
    localparam int N_VEC = 3;
    localparam logic [M-1:0] VEC_IN  [N_VEC] = '{M'(1), M'(2), (M'(1) << 192) | (M'(1) << 14)};
    localparam logic [M-1:0] VEC_EXP [N_VEC] = '{M'(1), (M'(1) << 192) | (M'(1) << 14), M'(2)};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [M-1:0] operand = '0;
    logic         done;
    logic [M-1:0] result;

    int tests = 0;
    int fails = 0;

    gf193_inverter i_gf193_inverter (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .operand (operand),
        .done    (done),
        .result  (result)
    );

    always #2 clk = ~clk;

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r;
        logic         top;
        r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            top = r[M-1];
            r = r << 1;
            if (top)  r = r ^ RED;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [M-1:0] rand_elem();
        logic [223:0] tmp;
        for (int w = 0; w < 7; w++) tmp[w*32 +: 32] = $urandom;
        if (tmp[M-1:0] == '0) return ONE;
        return tmp[M-1:0];
    endfunction

    task automatic chk(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Starts an inversion and waits for done; optionally pulses start again at step poke_at
    task automatic run_inv(input logic [M-1:0] a, input bit no_wait, input int poke_at,
                           input logic [M-1:0] poke_val, output logic [M-1:0] r, output int lat);
        if (!no_wait) @(negedge clk);
        start = 1'b1;
        operand = a;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (lat < 60) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) break;
            start = (lat == poke_at);
            operand = (lat == poke_at) ? poke_val : a;
        end
        start = 1'b0;
        r = result;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R5: watchdog expired, actual no end expected end before 20000 cycles");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [M-1:0] a, b, r, r_hold;
        int           lat, extra;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done in reset", M'(done), '0);
        chk("R1 result in reset", result, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", M'(done), '0);

        // R3 R4 table of known inverses
        for (int v = 0; v < N_VEC; v++) begin
            run_inv(VEC_IN[v], 1'b0, 0, '0, r, lat);
            chk((v == 0) ? "R3 inverse of one" : "R4 inverse of x pair", r, VEC_EXP[v]);
            chk("R5 latency", M'(lat), M'(EXP_LAT));
            @(negedge clk);
            chk("R5 single-cycle pulse", M'(done), '0);
        end

        // R2 random nonzero operands
        for (int n = 0; n < 8; n++) begin
            a = rand_elem();
            run_inv(a, 1'b0, 0, '0, r, lat);
            chk("R2 operand times result", ref_mul(a, r), ONE);
            chk("R5 latency random", M'(lat), M'(EXP_LAT));
        end

        // R7 result held while idle
        r_hold = result;
        extra = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R7 result stable while idle", result, r_hold);
        chk("R7 no done while idle", M'(extra), '0);

        // R6 start while busy is ignored
        a = rand_elem();
        b = rand_elem();
        run_inv(a, 1'b0, 6, b, r, lat);
        chk("R6 result of first request", ref_mul(a, r), ONE);
        chk("R6 latency unchanged", M'(lat), M'(EXP_LAT));
        extra = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R6 no extra done", M'(extra), '0);

        // R8 start in the done cycle is accepted
        a = rand_elem();
        b = rand_elem();
        run_inv(a, 1'b0, 0, '0, r, lat);
        chk("R8 first of back-to-back", ref_mul(a, r), ONE);
        run_inv(b, 1'b1, 0, '0, r, lat);
        chk("R8 second accepted in done cycle", ref_mul(b, r), ONE);
        chk("R8 second latency", M'(lat), M'(EXP_LAT));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule